// File: doc/BRIEF.md
# Streaming Sine Synthesizer

This block is a direct digital synthesizer. A 28-bit phase register advances by a programmable step, and the top ten phase bits select a sample of one sine cycle. Only a quarter of that cycle is stored; the other three quarters come from mirroring and negating it. Every clock in which the downstream side is ready carries one signed 16-bit sample on an AXI4-Stream master port.

The step (tuning word) comes in on a separate 32-bit AXI4-Stream slave port, which never pushes back. Only the low 28 bits of the word count. A new word changes the step size but leaves the phase where it is, so the frequency can move at run time without a jump in the waveform. At a 100 MS/s sample rate, a word of 0x28F5C2 gives about 1 MHz, and a word of 2^27 gives the highest usable rate, half the sample rate. The output is cut into packets: the sample taken just before the phase wraps past 2^28 carries TLAST, so each packet holds one full cycle of the waveform.

Top module: `sine_stream_dds`

## Requirements
- R1: A synchronous active-low reset clears the phase and the step to zero, drives m_tvalid, m_tlast and m_tdata to 0, and holds them there while reset is held. The first beat after release is the sample at phase 0.
- R2: From the first clock edge after reset is released, m_tvalid is 1 and stays 1 until the next reset.
- R3: While m_tvalid is 1 and m_tready is 0, m_tdata, m_tlast and the phase all hold their values.
- R4: s_tready is always 1. A word is accepted on any edge where s_tvalid is 1. Bits 27:0 become the step, and bits 31:28 have no effect. The new step is used from the next phase advance onward.
- R5: Loading a new step never changes the phase register. The waveform carries on from its current phase.
- R6: Each accepted output beat (m_tvalid and m_tready both 1) and the first beat after reset advance the phase by the step, modulo 2^28.
- R7: The sample for phase p is round(8191 * sin(2*pi*(a + 0.5)/1024)) within one LSB, where a = p[27:18]. The 14-bit signed value is sign-extended into m_tdata[15:0].
- R8: m_tlast is 1 exactly on a beat whose own advance carries the phase past 2^28.
- R9: m_tkeep is 2'b11 on every beat, including beats whose data is zero.
- R10: A step of 0x28F5C2 gives packets of 100 or 101 beats (1 MHz at 100 MS/s). A step of 0x8000000 gives packets of exactly 2 beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | 32 | Tuning word; bits 27:0 are the step |
| s_tvalid | input | 1 | Tuning word present |
| s_tready | output | 1 | Always 1 |
| m_tdata | output | 16 | Signed sine sample, sign-extended from 14 bits |
| m_tvalid | output | 1 | Sample present |
| m_tready | input | 1 | Downstream accepts the sample |
| m_tlast | output | 1 | Last sample of a waveform cycle |
| m_tkeep | output | 2 | Byte keep, always 2'b11 |

## Verification
The assertions assume that s_tdata, s_tvalid and m_tready are stable around each rising edge and change only in step with the sample clock. The stall-hold and step-load properties also assume that m_tready may drop and rise on any cycle with no rule tying it to packet boundaries. The bench keeps to these assumptions by driving every input on the falling edge only. It varies m_tready at random, loads tuning words both while the stream flows and while it is stalled, and includes words with the upper four bits set.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Fixed-point sine of (2*idx+1)*pi/(4*2^tbl_bits), scaled to amp_max.
  // Taylor series to x^11 in Q28 arithmetic; error well under one LSB.
  function automatic int quarter_sine(input int idx, input int tbl_bits,
                                      input int amp_max);
    longint pi_q;
    longint x;
    longint x2;
    longint term;
    longint acc;
    pi_q = 64'sd843314857;
    x    = ((longint'(2) * longint'(idx) + longint'(1)) * pi_q)
           / (longint'(4) <<< tbl_bits);
    x2   = (x * x) >>> 28;
    term = x;
    acc  = x;
    for (int k = 1; k <= 5; k++) begin
      term = -((term * x2) >>> 28) / longint'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return int'((acc * longint'(amp_max) + (longint'(1) <<< 27)) >>> 28);
  endfunction

endpackage

// File: rtl/dds_tune_reg.sv
module dds_tune_reg #(
  parameter int IN_W  = 32,
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  s_tdata,
  input  logic             s_tvalid,
  output logic             s_tready,
  output logic [ACC_W-1:0] step
);

  logic unused_hi_bits;
  assign unused_hi_bits = ^s_tdata[IN_W-1:ACC_W];

  assign s_tready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
    end else if (s_tvalid) begin
      step <= s_tdata[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] phase,
  output logic             wrap
);

  logic [ACC_W:0] sum;

  assign sum  = {1'b0, phase} + {1'b0, step};
  assign wrap = sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (adv) begin
      phase <= sum[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut
  import dds_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 14
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [AMP_W-1:0] amp
);

  localparam int LUT_BITS = ADDR_W - 2;
  localparam int QN       = 2 ** LUT_BITS;
  localparam int AMP_MAX  = 2 ** (AMP_W - 1) - 1;

  logic signed [AMP_W-1:0] rom [QN];

  for (genvar i = 0; i < QN; i++) begin : g_rom
    assign rom[i] = AMP_W'(quarter_sine(i, LUT_BITS, AMP_MAX));
  end

  logic [1:0]              quad;
  logic [LUT_BITS-1:0]     idx;
  logic [LUT_BITS-1:0]     ridx;
  logic signed [AMP_W-1:0] mag;

  assign quad = addr[ADDR_W-1:ADDR_W-2];
  assign idx  = addr[LUT_BITS-1:0];
  assign ridx = quad[0] ? ~idx : idx;
  assign mag  = rom[ridx];
  assign amp  = quad[1] ? -mag : mag;

endmodule

// File: rtl/sine_stream_dds.sv
module sine_stream_dds #(
  parameter int IN_W   = 32,
  parameter int ACC_W  = 28,
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 14,
  parameter int OUT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  s_tdata,
  input  logic             s_tvalid,
  output logic             s_tready,
  output logic [OUT_W-1:0] m_tdata,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic             m_tlast,
  output logic [1:0]       m_tkeep
);

  localparam int EXT_W = OUT_W - AMP_W;

  logic [ACC_W-1:0]        step_q;
  logic [ACC_W-1:0]        phase_q;
  logic                    acc_wrap;
  logic                    adv;
  logic signed [AMP_W-1:0] amp;

  // Output register loads when empty or when the current beat is taken.
  assign adv = !m_tvalid || m_tready;

  dds_tune_reg #(.IN_W(IN_W), .ACC_W(ACC_W)) u_tune (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tdata  (s_tdata),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .step     (step_q)
  );

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .step  (step_q),
    .phase (phase_q),
    .wrap  (acc_wrap)
  );

  dds_sine_lut #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_lut (
    .addr (phase_q[ACC_W-1 -: ADDR_W]),
    .amp  (amp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tlast  <= 1'b0;
    end else if (adv) begin
      m_tvalid <= 1'b1;
      m_tdata  <= {{EXT_W{amp[AMP_W-1]}}, amp};
      m_tlast  <= acc_wrap;
    end
  end

  assign m_tkeep = 2'b11;

endmodule

// File: rtl/dds_checker.sv
module dds_checker #(
  parameter int IN_W  = 32,
  parameter int ACC_W = 28,
  parameter int AMP_W = 14,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IN_W-1:0]  s_tdata,
  input logic             s_tvalid,
  input logic [OUT_W-1:0] m_tdata,
  input logic             m_tvalid,
  input logic             m_tready,
  input logic             m_tlast,
  input logic             adv,
  input logic             wrap,
  input logic [ACC_W-1:0] phase,
  input logic [ACC_W-1:0] step
);

  a_r2_valid_stays: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |=> m_tvalid);

  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> ($stable(m_tdata) && $stable(m_tlast) && $stable(phase)));

  a_r4_step_load: assert property (@(posedge clk) disable iff (!rst_n)
    s_tvalid |=> (step == $past(s_tdata[ACC_W-1:0])));

  a_r5_load_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && !adv) |=> $stable(phase));

  a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tdata[OUT_W-1:AMP_W] == {(OUT_W-AMP_W){m_tdata[AMP_W-1]}}));

  a_r8_last_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (m_tlast == $past(wrap)));

endmodule

bind sine_stream_dds dds_checker #(
  .IN_W(IN_W), .ACC_W(ACC_W), .AMP_W(AMP_W), .OUT_W(OUT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_tdata  (s_tdata),
  .s_tvalid (s_tvalid),
  .m_tdata  (m_tdata),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tlast  (m_tlast),
  .adv      (adv),
  .wrap     (acc_wrap),
  .phase    (phase_q),
  .step     (step_q)
);

// File: tb/sim_sine_stream_dds.sv
`timescale 1ns/1ps
module sim_sine_stream_dds;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] s_tdata;
  logic        s_tvalid;
  logic        s_tready;
  logic [15:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready;
  logic        m_tlast;
  logic [1:0]  m_tkeep;

  always #5 clk = ~clk;

  sine_stream_dds u0 (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast), .m_tkeep(m_tkeep)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [27:0] mphase;
  logic [27:0] mstep;
  bit          mvalid;
  int          exp_data[$];
  bit          exp_last[$];
  int          gaps[$];
  int          gap_cnt;
  bit          seen_last;
  bit          was_valid;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_sample(input logic [27:0] ph);
    real ang;
    ang = 2.0 * 3.14159265358979 * (real'(ph[27:18]) + 0.5) / 1024.0;
    return int'(8191.0 * $sin(ang));
  endfunction

  task automatic model_reset();
    mphase = '0; mstep = '0; mvalid = 0;
    exp_data.delete(); exp_last.delete();
    gaps.delete(); gap_cnt = 0; seen_last = 0; was_valid = 0;
  endtask

  // Driver: applies inputs for the next rising edge and predicts its load.
  task automatic apply(input bit rdy, input bit tv, input logic [31:0] td);
    logic [28:0] s;
    m_tready = rdy; s_tvalid = tv; s_tdata = td;
    if (rst_n) begin
      if (!mvalid || rdy) begin
        s = {1'b0, mphase} + {1'b0, mstep};
        exp_data.push_back(ref_sample(mphase));
        exp_last.push_back(s[28]);
        mphase = s[27:0];
        mvalid = 1;
      end
      if (tv) mstep = td[27:0];
    end
  endtask

  task automatic cycle(input bit rdy, input bit tv, input logic [31:0] td);
    @(negedge clk);
    apply(rdy, tv, td);
  endtask

  task automatic clear_gaps();
    gaps.delete(); gap_cnt = 0; seen_last = 0;
  endtask

  // Monitor: 8 ns after each rising edge, inputs for the next edge are set.
  always @(posedge clk) begin
    #8;
    if (rst_n && !done) begin
      if (was_valid && !m_tvalid)
        chk(0, "R2", "m_tvalid dropped", 0, 1);
      if (m_tvalid) begin
        was_valid = 1;
        if (exp_data.size() == 0) begin
          chk(0, "R2", "unexpected beat", 1, 0);
        end else begin
          int act;
          int d;
          act = int'($signed(m_tdata));
          d = act - exp_data[0];
          chk(d <= 1 && d >= -1, "R5 R6 R7", "sample", act, exp_data[0]);
          chk(m_tlast == exp_last[0], "R8", "tlast", m_tlast, exp_last[0]);
          chk(m_tkeep == 2'b11, "R9", "tkeep", m_tkeep, 3);
          chk(s_tready == 1'b1, "R4", "s_tready", s_tready, 1);
          if (m_tready) begin
            void'(exp_data.pop_front());
            void'(exp_last.pop_front());
            gap_cnt++;
            if (m_tlast) begin
              if (seen_last) gaps.push_back(gap_cnt);
              seen_last = 1;
              gap_cnt = 0;
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap_d;
    logic        snap_l;
    int          r0;
    rst_n = 0; m_tready = 0; s_tvalid = 0; s_tdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk(m_tvalid == 0, "R1", "valid in reset", m_tvalid, 0);
    chk(m_tlast == 0, "R1", "tlast in reset", m_tlast, 0);
    chk(m_tdata == 0, "R1", "data in reset", m_tdata, 0);
    chk(s_tready == 1, "R4", "s_tready in reset", s_tready, 1);

    // release, step 0: constant sample of phase 0
    @(negedge clk); rst_n = 1; apply(1, 0, 0);
    cycle(1, 0, 0);
    r0 = ref_sample(28'd0);
    chk(m_tvalid == 1, "R2", "valid after release", m_tvalid, 1);
    chk(int'($signed(m_tdata)) - r0 <= 1 && int'($signed(m_tdata)) - r0 >= -1,
        "R1", "first beat", int'($signed(m_tdata)), r0);
    repeat (4) cycle(1, 0, 0);

    // 1 MHz word
    cycle(1, 1, 32'h0028F5C2);
    repeat (50) cycle(1, 0, 0);
    clear_gaps();
    repeat (420) cycle(1, 0, 0);
    chk(gaps.size() >= 3, "R10", "1 MHz packets seen", gaps.size(), 3);
    foreach (gaps[i]) chk(gaps[i] == 100 || gaps[i] == 101, "R10", "1 MHz packet length", gaps[i], 100);

    // random backpressure
    cycle(1, 1, 32'h01234567);
    for (int i = 0; i < 400; i++) cycle($urandom_range(0, 3) != 0, 0, 0);

    // stall with tuning load: outputs hold
    cycle(0, 0, 0);
    @(negedge clk); snap_d = m_tdata; snap_l = m_tlast;
    apply(0, 1, 32'h05000000);
    repeat (4) cycle(0, 1, 32'h03000000);
    chk(m_tdata == snap_d, "R3", "data held in stall", m_tdata, snap_d);
    chk(m_tlast == snap_l, "R3", "tlast held in stall", m_tlast, snap_l);
    repeat (20) cycle(1, 0, 0);

    // retune on the fly, mixed readiness
    for (int i = 0; i < 60; i++)
      cycle($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, $urandom());
    repeat (10) cycle(1, 0, 0);

    // upper bits ignored: 0xF4000000 acts as 0x4000000
    cycle(1, 1, 32'hF4000000);
    repeat (20) cycle(1, 0, 0);
    clear_gaps();
    repeat (40) cycle(1, 0, 0);
    chk(gaps.size() >= 5, "R4", "upper-bit packets seen", gaps.size(), 5);
    foreach (gaps[i]) chk(gaps[i] == 4, "R4", "upper bits ignored, packet length", gaps[i], 4);

    // half sample rate
    cycle(1, 1, 32'h08000000);
    repeat (10) cycle(1, 0, 0);
    clear_gaps();
    repeat (30) cycle(1, 0, 0);
    chk(gaps.size() >= 5, "R10", "Nyquist packets seen", gaps.size(), 5);
    foreach (gaps[i]) chk(gaps[i] == 2, "R10", "Nyquist packet length", gaps[i], 2);

    // reset mid-stream
    @(negedge clk); rst_n = 0; model_reset(); apply(1, 0, 0);
    repeat (2) cycle(1, 0, 0);
    chk(m_tvalid == 0, "R1", "valid after mid reset", m_tvalid, 0);
    @(negedge clk); rst_n = 1; apply(1, 0, 0);
    cycle(1, 0, 0);
    chk(int'($signed(m_tdata)) - r0 <= 1 && int'($signed(m_tdata)) - r0 >= -1,
        "R1", "phase cleared by reset", int'($signed(m_tdata)), r0);
    chk(m_tlast == 0, "R8", "no tlast with zero step", m_tlast, 0);
    repeat (3) cycle(1, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule